// File: doc/BRIEF.md
# Serial Autobaud Lock with Acknowledge and Host Hold-Off

This block sits in front of a 16x-oversampling UART and works out the bit rate of a host that has not yet been told what rate to use. Once armed, it watches the idle-high receive line for a single sync character, the value 0x40 framed as 8N1. Sent LSB first, that character holds the line low for seven bit times from the falling edge of the start bit. The block counts that low stretch in core clocks and turns the count into a 16-bit UART divisor. The rest of the character is then checked against the measured bit time. A character that fails the check is thrown away and detection starts again.

When the character is accepted, the divisor is placed on the divisor output. A four-byte acknowledgement is then sent on the transmit line at the new rate. The block raises its locked flag only after the last stop bit of that acknowledgement. A host-wait output holds the host off from reset until lock. After lock it rises again for one character time whenever the host starts a byte, so the host samples it before each byte it sends.

Top module: `autobaud_sync`

## Requirements
- R1: After reset, txd is high, host_wait is high, locked is low and divisor is 0.
- R2: While arm is low, the block ignores all activity on rxd. No acknowledgement is sent and the divisor stays 0.
- R3: divisor = floor((L + 56) / 112), where L is the number of clocks rxd was low from the start-bit falling edge to the first rising edge (7 bit times of 0x40 sent LSB first). This is L/112 rounded half up. A result of 0 becomes 1, and a result above 2^DIV_W-1 saturates to that value.
- R4: A falling edge on rxd counts as a start bit only after the line has been high for at least IDLE_MIN (default 16) consecutive clocks since arming or since the last rejected attempt.
- R5: After the low stretch, the line must show one high bit and then one low bit, each within ±25% of L/7. It must then stay high for at least 3/4 of L/7. On any violation the measurement is discarded, nothing is sent, the divisor stays unchanged and detection rearms.
- R6: The acknowledgement is four 8N1 frames, sent LSB first with a bit period of 16·divisor clocks. The bytes are, in order: 0xBF, divisor[7:0], divisor[15:8], 0x00.
- R7: locked stays low until the final stop bit of the acknowledgement has completed. It then rises within 4 clocks and stays high until reset.
- R8: host_wait stays high from reset until locked rises, and drops to low within 4 clocks of lock while rxd is idle.
- R9: After lock, a falling edge on an idle rxd raises host_wait within 4 clocks. host_wait stays high for 160·divisor clocks (one 10-bit character) and then returns low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm | input | 1 | Level enable that lets detection start |
| rxd | input | 1 | Serial receive line from the host, idle high |
| txd | output | 1 | Serial transmit line to the host, idle high |
| host_wait | output | 1 | High: host must not send the next byte |
| divisor | output | DIV_W | Computed UART divisor (16x oversampling) |
| locked | output | 1 | High once the acknowledgement has fully left |

## Verification
The assertions assume that rst_n is low at time zero and that the host holds rxd high except while it is sending framed characters. They also assume the host bit period is constant within a character and at least a few clocks long, so the ±25% windows and the 16x-based transmit timing are meaningful. The stimulus drives rxd only on falling clock edges with whole-clock bit periods. It leaves at least 30 idle clocks before any character it expects to be accepted. It sends post-lock bytes only at the host rate already measured, so every window the checks rely on holds.

// File: rtl/autobaud_pkg.sv
package autobaud_pkg;

   typedef enum logic [2:0] {
      MS_IDLE,
      MS_QUIET,
      MS_ARM,
      MS_LOW,
      MS_HIGH,
      MS_DIP,
      MS_STOP,
      MS_DONE
   } meas_st_e;

   // the sync character keeps the line low for this many bit times
   localparam int SYNC_LOW_BITS = 7;
   // samples per bit of the downstream UART
   localparam int OVS           = 16;
   // start + 8 data + stop
   localparam int FRAME_BITS    = 10;
   // last acknowledgement byte
   localparam logic [7:0] ACK_TAIL = 8'h00;

endpackage

// File: rtl/autobaud_meter.sv
module autobaud_meter
   import autobaud_pkg::*;
#(
   parameter int CNT_W    = 24,
   parameter int IDLE_MIN = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             arm,
   input  logic             rx_s,
   output logic             meas_valid,
   output logic [CNT_W-1:0] low_cnt
);

   localparam int PW = CNT_W + 6;
   localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] QUIET_LM = CNT_W'(IDLE_MIN - 1);
   localparam int WIN_MUL = 4 * SYNC_LOW_BITS;

   if (CNT_W < 8) begin : g_bad_cnt
      $error("autobaud_meter: CNT_W must be at least 8");
   end
   if (IDLE_MIN < 2) begin : g_bad_idle
      $error("autobaud_meter: IDLE_MIN must be at least 2");
   end

   meas_st_e         st;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] low_q;
   logic [PW-1:0]    run_scaled;
   logic [PW-1:0]    lim_lo;
   logic [PW-1:0]    lim_hi;
   logic             too_short;
   logic             too_long;

   // bit time T = low_q/7 ; window [0.75T, 1.25T] scaled by 28
   assign run_scaled = PW'(cnt) * PW'(WIN_MUL);
   assign lim_lo     = PW'(low_q) * PW'(3);
   assign lim_hi     = PW'(low_q) * PW'(5);
   assign too_short  = run_scaled < lim_lo;
   assign too_long   = run_scaled > lim_hi;
   assign low_cnt    = low_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= MS_IDLE;
         cnt        <= '0;
         low_q      <= '0;
         meas_valid <= 1'b0;
      end else begin
         meas_valid <= 1'b0;
         case (st)
            MS_IDLE: begin
               if (arm) begin
                  st  <= MS_QUIET;
                  cnt <= '0;
               end
            end
            MS_QUIET: begin
               if (!rx_s) begin
                  cnt <= '0;
               end else if (cnt >= QUIET_LM) begin
                  st <= MS_ARM;
               end else begin
                  cnt <= cnt + CNT_W'(1);
               end
            end
            MS_ARM: begin
               if (!rx_s) begin
                  st  <= MS_LOW;
                  cnt <= CNT_W'(1);
               end
            end
            MS_LOW: begin
               if (rx_s) begin
                  low_q <= cnt;
                  st    <= MS_HIGH;
                  cnt   <= CNT_W'(1);
               end else if (cnt == CNT_MAX) begin
                  st  <= MS_QUIET;
                  cnt <= '0;
               end else begin
                  cnt <= cnt + CNT_W'(1);
               end
            end
            MS_HIGH: begin
               if (!rx_s) begin
                  if (too_short) begin
                     st  <= MS_QUIET;
                     cnt <= '0;
                  end else begin
                     st  <= MS_DIP;
                     cnt <= CNT_W'(1);
                  end
               end else if (too_long) begin
                  st  <= MS_QUIET;
                  cnt <= '0;
               end else begin
                  cnt <= cnt + CNT_W'(1);
               end
            end
            MS_DIP: begin
               if (rx_s) begin
                  if (too_short) begin
                     st  <= MS_QUIET;
                     cnt <= '0;
                  end else begin
                     st  <= MS_STOP;
                     cnt <= CNT_W'(1);
                  end
               end else if (too_long) begin
                  st  <= MS_QUIET;
                  cnt <= '0;
               end else begin
                  cnt <= cnt + CNT_W'(1);
               end
            end
            MS_STOP: begin
               if (!rx_s) begin
                  st  <= MS_QUIET;
                  cnt <= '0;
               end else if (!too_short) begin
                  st         <= MS_DONE;
                  meas_valid <= 1'b1;
               end else begin
                  cnt <= cnt + CNT_W'(1);
               end
            end
            default: begin
               st <= MS_DONE;
            end
         endcase
      end
   end

   // R5
   single_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      meas_valid |=> (!meas_valid && st == MS_DONE));

endmodule

// File: rtl/autobaud_divround.sv
module autobaud_divround #(
   parameter int CNT_W = 24,
   parameter int DIV_W = 16,
   parameter int DENOM = 112,
   parameter int SEQ   = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CNT_W-1:0] dividend,
   output logic             done,
   output logic [DIV_W-1:0] quot
);

   localparam int NW = CNT_W + 1;
   localparam int RW = $clog2(DENOM) + 1;
   localparam int SW = $clog2(NW + 1);
   localparam logic [NW-1:0] HALF  = NW'(DENOM / 2);
   localparam logic [NW-1:0] Q_TOP = NW'({DIV_W{1'b1}});

   if (CNT_W < DIV_W) begin : g_bad_w
      $error("autobaud_divround: CNT_W must not be below DIV_W");
   end
   if (DENOM < 2) begin : g_bad_d
      $error("autobaud_divround: DENOM must be at least 2");
   end

   logic [NW-1:0] num;
   assign num = {1'b0, dividend} + HALF;

   function automatic logic [DIV_W-1:0] clampq(input logic [NW-1:0] q);
      if (q == '0) begin
         return DIV_W'(1);
      end else if (q > Q_TOP) begin
         return {DIV_W{1'b1}};
      end else begin
         return q[DIV_W-1:0];
      end
   endfunction

   if (SEQ == 0) begin : g_comb
      logic [NW-1:0] q_w;
      assign q_w = num / NW'(DENOM);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            done <= 1'b0;
            quot <= '0;
         end else begin
            done <= start;
            if (start) begin
               quot <= clampq(q_w);
            end
         end
      end
   end else begin : g_seq
      logic [NW-1:0] num_sh;
      logic [NW-1:0] quo_sh;
      logic [NW-1:0] q_fin;
      logic [RW-1:0] rem;
      logic [RW-1:0] rem_nx;
      logic [RW-1:0] rem_up;
      logic [SW-1:0] step;
      logic          busy;
      logic          take;

      assign rem_nx = {rem[RW-2:0], num_sh[NW-1]};
      assign take   = rem_nx >= RW'(DENOM);
      assign rem_up = take ? (rem_nx - RW'(DENOM)) : rem_nx;
      assign q_fin  = {quo_sh[NW-2:0], take};

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            done   <= 1'b0;
            quot   <= '0;
            num_sh <= '0;
            quo_sh <= '0;
            rem    <= '0;
            step   <= '0;
            busy   <= 1'b0;
         end else begin
            done <= 1'b0;
            if (!busy) begin
               if (start) begin
                  busy   <= 1'b1;
                  num_sh <= num;
                  quo_sh <= '0;
                  rem    <= '0;
                  step   <= '0;
               end
            end else begin
               num_sh <= num_sh << 1;
               rem    <= rem_up;
               quo_sh <= q_fin;
               step   <= step + SW'(1);
               if (step == SW'(NW - 1)) begin
                  busy <= 1'b0;
                  done <= 1'b1;
                  quot <= clampq(q_fin);
               end
            end
         end
      end
   end

   // R3
   quot_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (quot != '0));

endmodule

// File: rtl/autobaud_acktx.sv
module autobaud_acktx
   import autobaud_pkg::*;
#(
   parameter int         DIV_W = 16,
   parameter logic [7:0] HEAD  = 8'hBF
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [DIV_W-1:0] div,
   output logic             txd,
   output logic             busy,
   output logic             done
);

   localparam int TW = DIV_W + 4;

   if (DIV_W < 2 || DIV_W > 16) begin : g_bad_div
      $error("autobaud_acktx: DIV_W must lie in 2..16");
   end

   logic [DIV_W-1:0] div_q;
   logic [15:0]      div16;
   logic [TW-1:0]    bit_len;
   logic [TW-1:0]    tcnt;
   logic [9:0]       sh;
   logic [3:0]       bitn;
   logic [1:0]       byten;

   assign div16   = 16'(div_q);
   assign bit_len = {div_q, 4'b0000};

   function automatic logic [7:0] ack_byte(input logic [1:0] idx, input logic [15:0] d);
      case (idx)
         2'd0:    return HEAD;
         2'd1:    return d[7:0];
         2'd2:    return d[15:8];
         default: return ACK_TAIL;
      endcase
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         done  <= 1'b0;
         txd   <= 1'b1;
         sh    <= '1;
         tcnt  <= '0;
         bitn  <= '0;
         byten <= '0;
         div_q <= '0;
      end else begin
         done <= 1'b0;
         if (!busy) begin
            if (start) begin
               busy  <= 1'b1;
               div_q <= div;
               byten <= '0;
               bitn  <= '0;
               tcnt  <= '0;
               sh    <= {1'b1, HEAD, 1'b0};
               txd   <= 1'b0;
            end
         end else if (tcnt == bit_len - TW'(1)) begin
            tcnt <= '0;
            if (bitn == 4'd9) begin
               if (byten == 2'd3) begin
                  busy <= 1'b0;
                  done <= 1'b1;
                  txd  <= 1'b1;
               end else begin
                  byten <= byten + 2'd1;
                  bitn  <= '0;
                  sh    <= {1'b1, ack_byte(byten + 2'd1, div16), 1'b0};
                  txd   <= 1'b0;
               end
            end else begin
               bitn <= bitn + 4'd1;
               sh   <= {1'b1, sh[9:1]};
               txd  <= sh[1];
            end
         end else begin
            tcnt <= tcnt + TW'(1);
         end
      end
   end

   // R6
   idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> txd);

endmodule

// File: rtl/autobaud_hostgate.sv
module autobaud_hostgate
   import autobaud_pkg::*;
#(
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             locked,
   input  logic             rx_s,
   input  logic [DIV_W-1:0] div,
   output logic             host_wait
);

   localparam int HW_W = DIV_W + 8;

   logic [HW_W-1:0] hold_len;
   logic [HW_W-1:0] hold_cnt;
   logic            rx_prev;

   assign hold_len = HW_W'(div) * HW_W'(FRAME_BITS * OVS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         host_wait <= 1'b1;
         hold_cnt  <= '0;
         rx_prev   <= 1'b1;
      end else begin
         rx_prev <= rx_s;
         if (!locked) begin
            host_wait <= 1'b1;
            hold_cnt  <= '0;
         end else if (host_wait) begin
            if (hold_cnt == '0) begin
               host_wait <= 1'b0;
            end else begin
               hold_cnt <= hold_cnt - HW_W'(1);
            end
         end else if (rx_prev && !rx_s) begin
            host_wait <= 1'b1;
            hold_cnt  <= hold_len - HW_W'(1);
         end
      end
   end

   // R8
   early_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(host_wait) |-> locked);

endmodule

// File: rtl/autobaud_sync.sv
module autobaud_sync
   import autobaud_pkg::*;
#(
   parameter int         CNT_W       = 24,
   parameter int         DIV_W       = 16,
   parameter int         SYNC_STAGES = 2,
   parameter int         IDLE_MIN    = 16,
   parameter logic [7:0] ACK_HEAD    = 8'hBF,
   parameter int         DIV_SEQ     = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             arm,
   input  logic             rxd,
   output logic             txd,
   output logic             host_wait,
   output logic [DIV_W-1:0] divisor,
   output logic             locked
);

   localparam int DENOM = OVS * SYNC_LOW_BITS;

   if (SYNC_STAGES < 1) begin : g_bad_sync
      $error("autobaud_sync: SYNC_STAGES must be at least 1");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   rx_s;
   logic                   meas_valid;
   logic [CNT_W-1:0]       low_cnt;
   logic                   div_done;
   logic [DIV_W-1:0]       div_val;
   logic                   tx_busy;
   logic                   tx_done;

   if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sync_q <= '1;
         else        sync_q <= rxd;
      end
   end else begin : g_syncn
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sync_q <= '1;
         else        sync_q <= {sync_q[SYNC_STAGES-2:0], rxd};
      end
   end
   assign rx_s = sync_q[SYNC_STAGES-1];

   autobaud_meter #(
      .CNT_W    (CNT_W),
      .IDLE_MIN (IDLE_MIN)
   ) meter_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .arm        (arm),
      .rx_s       (rx_s),
      .meas_valid (meas_valid),
      .low_cnt    (low_cnt)
   );

   autobaud_divround #(
      .CNT_W (CNT_W),
      .DIV_W (DIV_W),
      .DENOM (DENOM),
      .SEQ   (DIV_SEQ)
   ) div_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (meas_valid),
      .dividend (low_cnt),
      .done     (div_done),
      .quot     (div_val)
   );

   autobaud_acktx #(
      .DIV_W (DIV_W),
      .HEAD  (ACK_HEAD)
   ) ack_i (
      .clk   (clk),
      .rst_n (rst_n),
      .start (div_done),
      .div   (div_val),
      .txd   (txd),
      .busy  (tx_busy),
      .done  (tx_done)
   );

   autobaud_hostgate #(
      .DIV_W (DIV_W)
   ) gate_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .locked    (locked),
      .rx_s      (rx_s),
      .div       (divisor),
      .host_wait (host_wait)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         divisor <= '0;
         locked  <= 1'b0;
      end else begin
         if (div_done) divisor <= div_val;
         if (tx_done)  locked  <= 1'b1;
      end
   end

   // R7
   lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      locked |=> locked);

   // R7
   lock_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(locked) |-> (txd && !tx_busy));

   // R8
   wait_before_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !locked |-> host_wait);

   // R3
   divisor_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      locked |-> (divisor != '0));

endmodule

// File: tb/autobaud_sync_tb.sv
module autobaud_sync_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        arm = 1'b0;
   logic        rxd = 1'b1;
   logic        txd;
   logic        host_wait;
   logic [15:0] divisor;
   logic        locked;

   int vectors = 0;
   int misses  = 0;
   int tx_falls = 0;
   int cyc = 0;

   always #4 clk = ~clk;

   autobaud_sync dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .arm       (arm),
      .rxd       (rxd),
      .txd       (txd),
      .host_wait (host_wait),
      .divisor   (divisor),
      .locked    (locked)
   );

   always @(negedge txd) begin
      if (rst_n) tx_falls++;
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         misses++;
         $display("FAIL watchdog: actual %0d cycles expected below 150000", cyc);
         $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
         $finish;
      end
   end

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         misses++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic do_reset(input logic en);
      rst_n = 1'b0;
      arm   = en;
      rxd   = 1'b1;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      tx_falls = 0;
      repeat (2) @(negedge clk);
   endtask

   task automatic send_char(input logic [7:0] b, input int bt);
      @(negedge clk);
      rxd = 1'b0;
      repeat (bt) @(negedge clk);
      for (int i = 0; i < 8; i++) begin
         rxd = b[i];
         repeat (bt) @(negedge clk);
      end
      rxd = 1'b1;
      repeat (bt) @(negedge clk);
   endtask

   // returns at the middle of data bit 7
   task automatic recv_byte(input int bt, output logic [7:0] b);
      wait (txd === 1'b0);
      repeat (bt / 2) @(negedge clk);
      for (int i = 0; i < 8; i++) begin
         repeat (bt) @(negedge clk);
         b[i] = txd;
      end
   endtask

   function automatic int exp_div(input int bt);
      int q;
      q = (7 * bt + 56) / 112;
      if (q == 0) q = 1;
      return q;
   endfunction

   task automatic run_lock(input int bt);
      int         ed;
      int         tb;
      logic [7:0] got [4];
      ed = exp_div(bt);
      tb = 16 * ed;
      fork
         send_char(8'h40, bt);
         begin
            for (int k = 0; k < 4; k++) begin
               recv_byte(tb, got[k]);
               repeat (tb) @(negedge clk);
               if (k < 3) chk("R6", "stop bit", txd, 1);
            end
         end
      join
      // now in the middle of the last stop bit
      chk("R7", "locked before last stop ends", locked, 0);
      chk("R6", "last stop bit high", txd, 1);
      chk("R3", "divisor value", divisor, ed);
      chk("R6", "ack byte 0", got[0], 8'hBF);
      chk("R6", "ack byte 1", got[1], ed & 8'hFF);
      chk("R6", "ack byte 2", got[2], (ed >> 8) & 8'hFF);
      chk("R6", "ack byte 3", got[3], 8'h00);
      chk("R8", "host_wait held during ack", host_wait, 1);
      repeat (tb / 2 + 4) @(negedge clk);
      chk("R7", "locked after ack", locked, 1);
      repeat (3) @(negedge clk);
      chk("R8", "host_wait released after lock", host_wait, 0);
      chk("R7", "locked still high", locked, 1);
   endtask

   task automatic t_reset_state();
      do_reset(1'b1);
      chk("R1", "txd idle", txd, 1);
      chk("R1", "host_wait", host_wait, 1);
      chk("R1", "locked", locked, 0);
      chk("R1", "divisor", divisor, 0);
   endtask

   task automatic t_disarmed();
      do_reset(1'b0);
      repeat (30) @(negedge clk);
      send_char(8'h40, 48);
      repeat (300) @(negedge clk);
      chk("R2", "tx activity while disarmed", tx_falls, 0);
      chk("R2", "locked while disarmed", locked, 0);
      chk("R2", "divisor while disarmed", divisor, 0);
      chk("R2", "host_wait while disarmed", host_wait, 1);
   endtask

   task automatic t_rate(input int bt);
      do_reset(1'b1);
      repeat (30) @(negedge clk);
      run_lock(bt);
   endtask

   task automatic t_short_idle();
      do_reset(1'b1);
      repeat (6) @(negedge clk);
      send_char(8'h40, 48);
      repeat (300) @(negedge clk);
      chk("R4", "no lock after short idle", locked, 0);
      chk("R4", "no tx after short idle", tx_falls, 0);
      chk("R4", "divisor untouched", divisor, 0);
      repeat (30) @(negedge clk);
      run_lock(48);
   endtask

   task automatic t_bad_char();
      do_reset(1'b1);
      repeat (30) @(negedge clk);
      send_char(8'h41, 160);
      repeat (400) @(negedge clk);
      chk("R5", "no tx on wrong char", tx_falls, 0);
      chk("R5", "no lock on wrong char", locked, 0);
      chk("R5", "divisor discarded", divisor, 0);
      send_char(8'h00, 64);
      repeat (400) @(negedge clk);
      chk("R5", "no tx on all-zero char", tx_falls, 0);
      chk("R5", "divisor still discarded", divisor, 0);
      repeat (30) @(negedge clk);
      run_lock(160);
   endtask

   task automatic t_handshake();
      do_reset(1'b1);
      repeat (30) @(negedge clk);
      run_lock(48);
      repeat (20) @(negedge clk);
      fork
         send_char(8'h55, 48);
         begin
            @(negedge clk);
            repeat (24) @(negedge clk);
            chk("R9", "host_wait in start bit", host_wait, 1);
            repeat (432) @(negedge clk);
            chk("R9", "host_wait near end of char", host_wait, 1);
            repeat (48) @(negedge clk);
            chk("R9", "host_wait after char", host_wait, 0);
         end
      join
      chk("R9", "locked kept", locked, 1);
   endtask

   initial begin
      t_reset_state();
      t_disarmed();
      t_rate(160);
      t_rate(100);
      t_rate(120);
      t_rate(4);
      t_short_idle();
      t_bad_char();
      t_handshake();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end

endmodule